// File: doc/BRIEF.md
# Descriptor Chain Walking Sequencer

This block walks a singly linked list of transfer descriptors kept in a word-wide memory. Each descriptor takes eight 32-bit words. The sequencer fetches a descriptor and checks its hardware-ownership flag. It passes the transfer parameters to an external data mover over a request/done handshake, then writes the outcome back into the descriptor. After that it moves on to the descriptor named by the descriptor's link pointer.

A chain runs from a start pulse until the sequencer reaches a descriptor that hardware does not own, or until a failed transfer stops it while stop-on-error is enabled. With polling enabled, an unowned descriptor does not end the chain. The sequencer waits a programmable number of cycles and fetches it again. A synchronous software reset abandons whatever is in flight.

Top module: `dwalk_seq`

## Requirements
- R1: While reset is applied, and after it, with no start, `busy`, `mem_rd_req`, `mem_wr_req`, `mv_req`, `desc_done` and `chain_done` are all low. At most one of `mem_rd_req`, `mem_wr_req` and `mv_req` is high in any cycle.
- R2: A `start` seen while idle latches `first_desc` as the descriptor base. In the next cycle it issues a read at base+28 and raises `busy`. A `start` seen while busy has no effect on the fetch sequence.
- R3: Descriptor words are fetched one at a time, at offsets 28, 0, 8, 16 and 24 from the base, in that order. The meaning of each word:
  - offset 28: bits 31:24 hold the control byte.
  - offset 0: the read address.
  - offset 8: the write address.
  - offset 16: the link pointer.
  - offset 24: bits 15:0 hold the length, bits 23:16 the read burst and bits 31:24 the write burst.

  The mover receives these fields, with `mv_ctrl` = control bits {2,1,0} (write fixed, read fixed, end of packet).
- R4: If control bit 7 (word bit 31, the ownership flag) is clear and polling is off, no further word is fetched. `chain_done` pulses for one cycle, two cycles after that read request, and `busy` is already low in that cycle.
- R5: `mv_req` stays high until `mv_done` is seen. In the cycle after that, one write to base+28 carries {control byte, `mv_status`, `mv_xferred`} in bits 31:24, 23:16 and 15:0.
- R6: With `keep_own` low, the written control byte has bit 7 cleared. With `keep_own` high, the control byte is written back unchanged.
- R7: `desc_done` pulses in the cycle after each writeback. `desc_eop` is control bit 0 OR status bit 7. `desc_err` is the OR of status bits 5:0.
- R8: Unless the chain stops, the cycle after the writeback issues the read of the next descriptor's control word, at the link pointer plus 28.
- R9: With `poll_en` high and the ownership flag clear, the control word is fetched again after a delay set by `poll_interval` = P. Successive fetches are P+3 cycles apart and `busy` stays high throughout. Once the flag is found set, the walk proceeds.
- R10: With `stop_on_err` high, a writeback whose status has an error bit set ends the chain. No further fetch is made, and `chain_done` pulses in the same cycle as `desc_done`. With `stop_on_err` low, the chain continues.
- R11: `sw_reset` makes the next cycle idle, with no request active. Any pending writeback is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous abort to idle |
| start | input | 1 | Begin walking at `first_desc` |
| stop_on_err | input | 1 | Halt the chain after an erroring descriptor |
| keep_own | input | 1 | 1: leave ownership flag as is on writeback |
| poll_en | input | 1 | Re-fetch unowned descriptors instead of ending |
| poll_interval | input | POLL_W | Poll delay P |
| first_desc | input | ADDR_W | Byte address of the first descriptor |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | ADDR_W | Read byte address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the request |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_addr | output | ADDR_W | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mv_req | output | 1 | Transfer request to the mover |
| mv_rd_addr | output | ADDR_W | Source address |
| mv_wr_addr | output | ADDR_W | Destination address |
| mv_len | output | 16 | Byte count |
| mv_rd_burst | output | 8 | Read burst size |
| mv_wr_burst | output | 8 | Write burst size |
| mv_ctrl | output | 3 | {write fixed, read fixed, end of packet} |
| mv_done | input | 1 | Transfer finished (one-cycle pulse) |
| mv_xferred | input | 16 | Bytes moved |
| mv_status | input | 8 | Transfer status byte |
| busy | output | 1 | Chain in progress |
| desc_done | output | 1 | Descriptor written back (pulse) |
| desc_eop | output | 1 | End of packet for that descriptor |
| desc_err | output | 1 | Error reported for that descriptor |
| chain_done | output | 1 | Chain ended (pulse) |

## Verification
Each result has a fixed latency, and the checks use it:
- The first control-word read appears one cycle after `start` is sampled.
- The writeback follows the sampled `mv_done` by one cycle.
- `desc_done` and the next control-word read follow the writeback by one cycle.
- `chain_done` comes two cycles after the read of an unowned control word.

The bench logs every request with a cycle stamp taken between clock edges and compares these differences exactly. It does not wait loosely for an event. Poll spacing is measured as the stamp difference between consecutive control-word fetches (P+3). The aborted, stopped and ignored cases are confirmed by the read and write counts staying frozen over a quiet window.

// File: rtl/dwalk_pkg.sv
package dwalk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_CAPT,
      ST_MOVE,
      ST_WB,
      ST_POLL
   } dwalk_st_e;

   localparam int NFETCH   = 5;    // control word plus four payload words
   localparam int CTRL_OFF = 28;   // byte offset of the status/control word
   localparam int OWN_BIT  = 7;
   localparam int EOP_BIT  = 0;
   localparam int RX_EOP_BIT = 7;

   // fetch slot k: 0 -> control word, 1..4 -> words at 0, 8, 16, 24
   function automatic logic [4:0] fetch_off(input logic [2:0] k);
      logic [2:0] m;
      m = k - 3'd1;
      if (k == 3'd0) return 5'(CTRL_OFF);
      return {m[1:0], 3'b000};
   endfunction
endpackage

// File: rtl/dwalk_poll_timer.sv
module dwalk_poll_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/dwalk_desc_store.sv
module dwalk_desc_store
   import dwalk_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [2:0]        cap_idx,
   input  logic [31:0]       word,
   output logic [7:0]        ctrl,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] link,
   output logic [15:0]       len,
   output logic [7:0]        rd_burst,
   output logic [7:0]        wr_burst
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            ctrl <= '0;
      else if (cap_en && cap_idx == 3'd0)    ctrl <= word[31:24];
   end

   for (genvar gi = 1; gi < NFETCH; gi++) begin : g_w
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             q <= '0;
         else if (cap_en && cap_idx == 3'(gi))   q <= word;
      end
   end

   assign rd_addr  = g_w[1].q[ADDR_W-1:0];
   assign wr_addr  = g_w[2].q[ADDR_W-1:0];
   assign link     = g_w[3].q[ADDR_W-1:0];
   assign len      = g_w[4].q[15:0];
   assign rd_burst = g_w[4].q[23:16];
   assign wr_burst = g_w[4].q[31:24];
endmodule

// File: rtl/dwalk_seq.sv
module dwalk_seq
   import dwalk_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int POLL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_reset,
   input  logic              start,
   input  logic              stop_on_err,
   input  logic              keep_own,
   input  logic              poll_en,
   input  logic [POLL_W-1:0] poll_interval,
   input  logic [ADDR_W-1:0] first_desc,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [31:0]       mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [31:0]       mem_wr_data,
   output logic              mv_req,
   output logic [ADDR_W-1:0] mv_rd_addr,
   output logic [ADDR_W-1:0] mv_wr_addr,
   output logic [15:0]       mv_len,
   output logic [7:0]        mv_rd_burst,
   output logic [7:0]        mv_wr_burst,
   output logic [2:0]        mv_ctrl,
   input  logic              mv_done,
   input  logic [15:0]       mv_xferred,
   input  logic [7:0]        mv_status,
   output logic              busy,
   output logic              desc_done,
   output logic              desc_eop,
   output logic              desc_err,
   output logic              chain_done
);
   localparam logic [2:0] LAST_K = 3'(NFETCH - 1);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("dwalk_seq: ADDR_W must lie in 8..32");
   end
   if (POLL_W < 1 || POLL_W > 16) begin : g_bad_poll_w
      $error("dwalk_seq: POLL_W must lie in 1..16");
   end

   dwalk_st_e         st_q;
   logic [2:0]        k_q;
   logic [ADDR_W-1:0] base_q;
   logic [15:0]       xf_q;
   logic [7:0]        sts_q;
   logic [7:0]        ctrl;
   logic [ADDR_W-1:0] link;
   logic              owned;
   logic              tmr_load;
   logic              tmr_expired;
   logic              sts_err;
   logic [7:0]        ctrl_wb;

   assign owned    = mem_rd_data[24 + OWN_BIT];
   assign sts_err  = |sts_q[5:0];
   assign tmr_load = (st_q == ST_CAPT) && (k_q == 3'd0) && !owned && poll_en;
   assign ctrl_wb  = keep_own ? ctrl : (ctrl & ~(8'd1 << OWN_BIT));

   dwalk_desc_store #(.ADDR_W(ADDR_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (st_q == ST_CAPT),
      .cap_idx  (k_q),
      .word     (mem_rd_data),
      .ctrl     (ctrl),
      .rd_addr  (mv_rd_addr),
      .wr_addr  (mv_wr_addr),
      .link     (link),
      .len      (mv_len),
      .rd_burst (mv_rd_burst),
      .wr_burst (mv_wr_burst)
   );

   dwalk_poll_timer #(.W(POLL_W)) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (poll_interval),
      .expired  (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         k_q        <= '0;
         base_q     <= '0;
         xf_q       <= '0;
         sts_q      <= '0;
         desc_done  <= 1'b0;
         desc_eop   <= 1'b0;
         desc_err   <= 1'b0;
         chain_done <= 1'b0;
      end else begin
         desc_done  <= 1'b0;
         chain_done <= 1'b0;
         if (sw_reset) begin
            st_q <= ST_IDLE;
         end else begin
            unique case (st_q)
               ST_IDLE: if (start) begin
                  base_q <= first_desc;
                  k_q    <= '0;
                  st_q   <= ST_FETCH;
               end
               ST_FETCH: st_q <= ST_CAPT;
               ST_CAPT: begin
                  if (k_q == 3'd0 && !owned) begin
                     if (poll_en) st_q <= ST_POLL;
                     else begin
                        st_q       <= ST_IDLE;
                        chain_done <= 1'b1;
                     end
                  end else if (k_q == LAST_K) begin
                     st_q <= ST_MOVE;
                  end else begin
                     k_q  <= k_q + 3'd1;
                     st_q <= ST_FETCH;
                  end
               end
               ST_MOVE: if (mv_done) begin
                  xf_q  <= mv_xferred;
                  sts_q <= mv_status;
                  st_q  <= ST_WB;
               end
               ST_WB: begin
                  desc_done <= 1'b1;
                  desc_eop  <= ctrl[EOP_BIT] | sts_q[RX_EOP_BIT];
                  desc_err  <= sts_err;
                  k_q       <= '0;
                  base_q    <= link;
                  if (stop_on_err && sts_err) begin
                     st_q       <= ST_IDLE;
                     chain_done <= 1'b1;
                  end else begin
                     st_q <= ST_FETCH;
                  end
               end
               ST_POLL: if (tmr_expired) st_q <= ST_FETCH;
               default: st_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy        = (st_q != ST_IDLE);
   assign mem_rd_req  = (st_q == ST_FETCH);
   assign mem_rd_addr = base_q + ADDR_W'(fetch_off(k_q));
   assign mem_wr_req  = (st_q == ST_WB);
   assign mem_wr_addr = base_q + ADDR_W'(CTRL_OFF);
   assign mem_wr_data = {ctrl_wb, sts_q, xf_q};
   assign mv_req      = (st_q == ST_MOVE);
   assign mv_ctrl     = ctrl[2:0];
endmodule

module dwalk_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic sw_reset,
   input logic start,
   input logic busy,
   input logic mem_rd_req,
   input logic mem_wr_req,
   input logic mv_req,
   input logic mv_done,
   input logic desc_done,
   input logic chain_done
);
   a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_req, mem_wr_req, mv_req}));

   a_r2_start_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && !sw_reset |=> busy && mem_rd_req);

   a_r4_chain_idle: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done |-> !busy);

   a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req && !mv_done && !sw_reset |=> mv_req);

   a_r5_wb_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      mv_req && mv_done && !sw_reset |=> mem_wr_req);

   a_r7_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_req |=> desc_done);

   a_r11_abort: assert property (@(posedge clk) disable iff (!rst_n)
      sw_reset |=> !busy && !mv_req && !mem_rd_req && !mem_wr_req);
endmodule

bind dwalk_seq dwalk_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sw_reset   (sw_reset),
   .start      (start),
   .busy       (busy),
   .mem_rd_req (mem_rd_req),
   .mem_wr_req (mem_wr_req),
   .mv_req     (mv_req),
   .mv_done    (mv_done),
   .desc_done  (desc_done),
   .chain_done (chain_done)
);

// File: tb/dwalk_seq_bench.sv
`timescale 1ns/1ps
module dwalk_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sw_reset = 1'b0, start = 1'b0, stop_on_err = 1'b0;
   logic        keep_own = 1'b0, poll_en = 1'b0;
   logic [7:0]  poll_interval = 8'd0;
   logic [31:0] first_desc = 32'd0;
   logic        mem_rd_req, mem_wr_req, mv_req;
   logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data, mv_rd_addr, mv_wr_addr;
   logic [31:0] mem_rd_data = 32'd0;
   logic [15:0] mv_len;
   logic [7:0]  mv_rd_burst, mv_wr_burst;
   logic [2:0]  mv_ctrl;
   logic        mv_done = 1'b0;
   logic [15:0] mv_xferred = 16'd0;
   logic [7:0]  mv_status = 8'd0;
   logic        busy, desc_done, desc_eop, desc_err, chain_done;

   always #2.5 clk = ~clk;

   dwalk_seq u_dwalk_seq (.*);

   // memory and mover models
   logic [31:0] mem [0:63];
   int          mv_lat = 2, mv_cnt = 0;
   logic [15:0] mv_xf_v = 16'd0;
   logic [7:0]  mv_st_v = 8'd0;

   always @(posedge clk) begin
      if (mem_rd_req) mem_rd_data <= mem[mem_rd_addr[7:2]];
      if (mem_wr_req) mem[mem_wr_addr[7:2]] <= mem_wr_data;
      mv_done <= 1'b0;
      if (mv_req && !mv_done) begin
         if (mv_cnt == mv_lat) begin
            mv_done    <= 1'b1;
            mv_xferred <= mv_xf_v;
            mv_status  <= mv_st_v;
            mv_cnt     <= 0;
         end else mv_cnt <= mv_cnt + 1;
      end else if (!mv_req) mv_cnt <= 0;
   end

   // monitor, sampling between edges
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int          rd_n, wr_n, dd_n, cd_n;
   logic [31:0] rd_addr_log [0:31];
   int          rd_cyc_log [0:31];
   int          wr_cyc_first, wr_cyc_last, done_cyc, dd_cyc, cd_cyc, start_cyc;
   logic [31:0] wr_data_first, wr_data_last, wr_addr_last;
   logic        dd_eop, dd_err, cd_busy, mvf_seen;
   logic [31:0] mvf_raddr, mvf_waddr;
   logic [15:0] mvf_len;
   logic [7:0]  mvf_rb, mvf_wb;
   logic [2:0]  mvf_ctrl;

   always @(negedge clk) begin
      if (start && !busy) start_cyc = cyc;
      if (mem_rd_req) begin
         if (rd_n < 32) begin
            rd_addr_log[rd_n] = mem_rd_addr;
            rd_cyc_log[rd_n]  = cyc;
         end
         rd_n++;
      end
      if (mem_wr_req) begin
         if (wr_n == 0) begin
            wr_cyc_first  = cyc;
            wr_data_first = mem_wr_data;
         end
         wr_cyc_last = cyc; wr_data_last = mem_wr_data; wr_addr_last = mem_wr_addr;
         wr_n++;
      end
      if (mv_req && mv_done) done_cyc = cyc;
      if (mv_req && !mvf_seen) begin
         mvf_seen = 1'b1;
         mvf_raddr = mv_rd_addr; mvf_waddr = mv_wr_addr; mvf_len = mv_len;
         mvf_rb = mv_rd_burst; mvf_wb = mv_wr_burst; mvf_ctrl = mv_ctrl;
      end
      if (desc_done) begin
         dd_n++; dd_cyc = cyc; dd_eop = desc_eop; dd_err = desc_err;
      end
      if (chain_done) begin
         cd_n++; cd_cyc = cyc; cd_busy = busy;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic fresh();
      for (int i = 0; i < 64; i++) mem[i] = 32'd0;
      rd_n = 0; wr_n = 0; dd_n = 0; cd_n = 0; mvf_seen = 1'b0;
      stop_on_err = 1'b0; keep_own = 1'b0; poll_en = 1'b0; poll_interval = 8'd0;
      mv_lat = 2; mv_xf_v = 16'h0040; mv_st_v = 8'h00;
   endtask

   task automatic put_desc(input int base, input logic [31:0] ra, input logic [31:0] wa,
                           input logic [31:0] nxt, input logic [15:0] len,
                           input logic [7:0] rb, input logic [7:0] wb, input logic [7:0] ctl);
      mem[(base >> 2) + 0] = ra;
      mem[(base >> 2) + 2] = wa;
      mem[(base >> 2) + 4] = nxt;
      mem[(base >> 2) + 6] = {wb, rb, len};
      mem[(base >> 2) + 7] = {ctl, 24'h0};
   endtask

   task automatic launch(input logic [31:0] addr);
      first_desc = addr;
      start = 1'b1;
      tick(1);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      tick(2);
      while (busy && guard < 2000) begin
         tick(1);
         guard++;
      end
      tick(2);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick(3);
      chk("R1 busy in reset", busy, 0);
      chk("R1 requests in reset", {mem_rd_req, mem_wr_req, mv_req}, 0);
      rst_n = 1'b1;
      tick(3);
      chk("R1 idle after reset", {busy, desc_done, chain_done, mem_rd_req, mem_wr_req, mv_req}, 0);
   endtask

   task automatic t_chain();
      fresh();
      put_desc(32'h00, 32'h1000, 32'h2000, 32'h20, 16'h0040, 8'h04, 8'h08, 8'h82);
      put_desc(32'h20, 32'h1100, 32'h2100, 32'h40, 16'h0010, 8'h01, 8'h02, 8'h81);
      launch(32'h0);
      wait_idle();
      chk("R2 first read one cycle after start", rd_cyc_log[0], start_cyc + 1);
      chk("R2 first read address", rd_addr_log[0], 32'h1C);
      chk("R3 fetch offset slot1", rd_addr_log[1], 32'h00);
      chk("R3 fetch offset slot2", rd_addr_log[2], 32'h08);
      chk("R3 fetch offset slot3", rd_addr_log[3], 32'h10);
      chk("R3 fetch offset slot4", rd_addr_log[4], 32'h18);
      chk("R3 mover read address", mvf_raddr, 32'h1000);
      chk("R3 mover write address", mvf_waddr, 32'h2000);
      chk("R3 mover length and bursts", {mvf_len, mvf_rb, mvf_wb}, {16'h0040, 8'h04, 8'h08});
      chk("R3 mover control", mvf_ctrl, 3'b010);
      chk("R5 write one cycle after done", wr_cyc_last, done_cyc + 1);
      chk("R5 writeback address", wr_addr_last, 32'h3C);
      chk("R6 ownership cleared, first writeback", wr_data_first, 32'h02000040);
      chk("R6 ownership cleared, second writeback", wr_data_last, 32'h01000040);
      chk("R8 next control read follows writeback", rd_cyc_log[5], wr_cyc_first + 1);
      chk("R8 next control read address", rd_addr_log[5], 32'h3C);
      chk("R7 desc_done one cycle after writeback", dd_cyc, wr_cyc_last + 1);
      chk("R7 desc_done count and eop", {dd_n[7:0], 6'd0, dd_eop, dd_err}, {8'd2, 6'd0, 1'b1, 1'b0});
      chk("R4 stops at unowned descriptor", rd_n, 11);
      chk("R4 unowned control address", rd_addr_log[10], 32'h5C);
      chk("R4 chain_done timing", cd_cyc, rd_cyc_log[10] + 2);
      chk("R4 chain_done once, busy low", {cd_n[7:0], 7'd0, cd_busy}, {8'd1, 8'd0});
   endtask

   task automatic t_keep_own();
      fresh();
      keep_own = 1'b1;
      mv_xf_v = 16'h0033; mv_st_v = 8'h80;
      put_desc(32'h00, 32'h3000, 32'h4000, 32'h20, 16'h0033, 8'h00, 8'h00, 8'h84);
      launch(32'h0);
      wait_idle();
      chk("R6 control preserved with keep_own", wr_data_last, 32'h84800033);
      chk("R3 mover control write-fixed", mvf_ctrl, 3'b100);
      chk("R7 eop from status bit7, no error", {dd_n[7:0], 6'd0, dd_eop, dd_err}, {8'd1, 6'd0, 1'b1, 1'b0});
   endtask

   task automatic t_poll();
      fresh();
      poll_en = 1'b1; poll_interval = 8'd4;
      put_desc(32'h80, 32'h5000, 32'h6000, 32'hA0, 16'h0008, 8'h00, 8'h00, 8'h00);
      launch(32'h80);
      tick(20);
      chk("R9 still busy while polling", busy, 1);
      chk("R9 poll re-reads control word", rd_addr_log[1], 32'h9C);
      chk("R9 poll spacing P+3", rd_cyc_log[1] - rd_cyc_log[0], 7);
      chk("R9 poll spacing repeats", rd_cyc_log[2] - rd_cyc_log[1], 7);
      mem[(32'h9C) >> 2] = 32'h8000_0000;
      poll_en = 1'b0;
      wait_idle();
      chk("R9 proceeds once owned", {dd_n[7:0], cd_n[7:0]}, {8'd1, 8'd1});
   endtask

   task automatic t_stop(input logic stop);
      fresh();
      stop_on_err = stop;
      mv_st_v = 8'h05;
      put_desc(32'h00, 32'h1000, 32'h2000, 32'h20, 16'h0040, 8'h00, 8'h00, 8'h80);
      put_desc(32'h20, 32'h1100, 32'h2100, 32'h40, 16'h0040, 8'h00, 8'h00, 8'h80);
      launch(32'h0);
      wait_idle();
      if (stop) begin
         chk("R10 one descriptor then halt", {dd_n[7:0], cd_n[7:0]}, {8'd1, 8'd1});
         chk("R10 no fetch after halt", rd_n, 5);
         chk("R10 chain_done with desc_done", cd_cyc, dd_cyc);
         chk("R10 error flagged, status written", {7'd0, dd_err, wr_data_last}, {8'd1, 32'h00050040});
      end else begin
         chk("R10 chain continues without stop", {dd_n[7:0], cd_n[7:0]}, {8'd2, 8'd1});
         chk("R10 all descriptors fetched", rd_n, 11);
      end
   endtask

   task automatic t_abort();
      fresh();
      mv_lat = 20;
      put_desc(32'h00, 32'h1000, 32'h2000, 32'h20, 16'h0040, 8'h00, 8'h00, 8'h80);
      put_desc(32'h20, 32'h1100, 32'h2100, 32'h40, 16'h0040, 8'h00, 8'h00, 8'h80);
      launch(32'h0);
      for (int i = 0; i < 40 && !mv_req; i++) tick(1);
      first_desc = 32'h40;
      start = 1'b1;
      tick(1);
      start = 1'b0;
      tick(3);
      chk("R2 start while busy ignored", {rd_n[7:0], 7'd0, mv_req}, {8'd5, 8'd1});
      sw_reset = 1'b1;
      tick(1);
      sw_reset = 1'b0;
      tick(1);
      chk("R11 idle after sw_reset", {busy, mv_req, mem_rd_req, mem_wr_req}, 4'b0000);
      tick(30);
      chk("R11 no writeback or fetch after abort", {wr_n[7:0], rd_n[7:0]}, {8'd0, 8'd5});
   endtask

   initial begin
      fresh();
      tick(2);
      t_reset();
      t_chain();
      t_keep_own();
      t_poll();
      t_stop(1'b1);
      t_stop(1'b0);
      t_abort();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule